// File: doc/BRIEF.md
# Rotating-Priority Interrupt Resolver

This block arbitrates eight interrupt lines in the way a classic programmable interrupt controller does. It keeps three 8-bit registers: pending requests, lines in service, and a mask. A 3-bit rotating pointer names the line that currently has the lowest priority. Every cycle the block picks the highest-priority pending, unmasked request that outranks every line in service. It raises a registered interrupt output while such a request exists and the controller has been initialised.

A processor acknowledges with a one-cycle strobe. The block always presents the vector that an acknowledge would return: an aligned base with the winning line number in its three low bits. Neighbouring blocks deliver configuration (initialised flag, automatic-EOI mode, vector base, mask writes) and edge/level trigger detection (one-cycle set pulses plus the live line levels). End-of-interrupt and priority commands arrive on a small command port whose fields carry the EOI, specific and rotate flags and a 3-bit level.

Top module: `prio_irq_resolver`

## Requirements
- R1: After reset the pending, in-service and mask registers read 0, `irq` is low, and the pointer is 7, so line 0 has the highest priority and line 7 the lowest.
- R2: A `req_set` bit sets the matching pending bit on the next edge only while `init_done` is high. While `init_done` is low the pulse is ignored and the pending register keeps its value.
- R3: Priority runs upward from pointer+1, wrapping modulo 8. The line equal to the pointer is last.
- R4: A pending request counts only if it is unmasked and lies strictly earlier in scan order than the first in-service line. With no line in service, all eight positions count.
- R5: `irq` is a register. One edge after a counting request exists and `init_done` is high, it is high. Otherwise it is low.
- R6: `ack_vector` is {`vec_base`, line}, where line is the winning line. With no winning request it is {`vec_base`, 7}, and an acknowledge in that state changes no register.
- R7: On acknowledge, the winning line's pending bit is cleared only if its `line_level` bit is low.
- R8: On acknowledge with `aeoi_en` low, the winning line's in-service bit is set.
- R9: On acknowledge with `aeoi_en` high, no in-service bit is set. If the stored rotate flag is 1, the pointer is loaded with the acknowledged line.
- R10: A command with eoi=1 and specific=1 clears in-service bit `cmd_level`. If rotate=1, the pointer is loaded with that level.
- R11: A command with eoi=1 and specific=0 clears the highest-priority set in-service bit, and loads the pointer with it if rotate=1. With no bit in service it changes nothing.
- R12: A command with eoi=0, specific=1 and rotate=1 loads the pointer from `cmd_level`. Every command stores its rotate bit as the flag used by R9.
- R13: `mask_we` replaces the mask register with `mask_wdata` on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_done | input | 1 | Controller initialised; gates requests and `irq` |
| aeoi_en | input | 1 | Automatic end-of-interrupt mode |
| vec_base | input | 5 | Upper bits of the returned vector |
| mask_we | input | 1 | Mask register write strobe |
| mask_wdata | input | 8 | Mask value, 1 = line masked |
| req_set | input | 8 | One-cycle pulses from trigger detection |
| line_level | input | 8 | Current asserted state of each line |
| cmd_valid | input | 1 | Command strobe |
| cmd_eoi | input | 1 | Command is an end-of-interrupt |
| cmd_specific | input | 1 | Command uses `cmd_level` |
| cmd_rotate | input | 1 | Rotate flag carried by the command |
| cmd_level | input | 3 | Line number for specific commands |
| ack | input | 1 | Interrupt acknowledge strobe |
| irq | output | 1 | Registered interrupt request |
| ack_vector | output | 8 | Vector an acknowledge returns this cycle |
| irr_q | output | 8 | Pending request register |
| isr_q | output | 8 | In-service register |
| imr_q | output | 8 | Mask register |

## Verification
Register results (pending, in-service, mask, pointer) change on the edge that samples a strobe. The bench drives every strobe at a falling edge and reads the registers at the next falling edge. `ack_vector` is combinational from those registers, so it is read in the same half-cycle the acknowledge is driven, before the edge that acts on it. `irq` sits one register further out: it is checked two falling edges after a request pulse, and it is confirmed still low one falling edge after the pulse.

// File: rtl/irq_res_pkg.sv
package irq_res_pkg;
   // Decoded command flags travelling from the port to the command unit.
   typedef struct packed {
      logic eoi;
      logic specific;
      logic rotate;
   } irq_cmd_t;
endpackage

// File: rtl/irq_prio_scan.sv
// Rotated priority encoder: position 0 is line ptr+1, last is line ptr.
module irq_prio_scan #(
   parameter int NUM_LINES = 8,
   parameter int PTR_W     = $clog2(NUM_LINES)
) (
   input  logic [NUM_LINES-1:0] vec_i,
   input  logic [PTR_W-1:0]     ptr_i,
   output logic                 found_o,
   output logic [PTR_W-1:0]     pos_o,
   output logic [PTR_W-1:0]     pin_o
);
   logic [NUM_LINES-1:0] rot;

   for (genvar gi = 0; gi < NUM_LINES; gi++) begin : g_rot
      logic [PTR_W-1:0] src;
      assign src     = ptr_i + PTR_W'(1) + PTR_W'(gi);
      assign rot[gi] = vec_i[src];
   end

   always_comb begin
      found_o = 1'b0;
      pos_o   = '0;
      for (int i = NUM_LINES - 1; i >= 0; i--) begin
         if (rot[i]) begin
            found_o = 1'b1;
            pos_o   = PTR_W'(i);
         end
      end
      pin_o = ptr_i + PTR_W'(1) + pos_o;
   end

   // R3: a reported winner must really be set in the scanned vector
   always_comb begin
      if (found_o) a_r3_pin_is_set : assert (vec_i[pin_o]);
   end
endmodule

// File: rtl/irq_cmd_unit.sv
// Turns an EOI / priority command into an in-service clear and a pointer load.
module irq_cmd_unit
   import irq_res_pkg::*;
#(
   parameter int PTR_W = 3
) (
   input  logic             cmd_valid_i,
   input  irq_cmd_t         cmd_i,
   input  logic [PTR_W-1:0] level_i,
   input  logic             isr_found_i,
   input  logic [PTR_W-1:0] isr_pin_i,
   output logic             clr_valid_o,
   output logic [PTR_W-1:0] clr_pin_o,
   output logic             ptr_load_o,
   output logic [PTR_W-1:0] ptr_val_o
);
   always_comb begin
      clr_valid_o = 1'b0;
      clr_pin_o   = level_i;
      ptr_load_o  = 1'b0;
      ptr_val_o   = level_i;
      if (cmd_valid_i) begin
         if (cmd_i.eoi) begin
            if (cmd_i.specific) begin
               clr_valid_o = 1'b1;
               clr_pin_o   = level_i;
            end else begin
               clr_valid_o = isr_found_i;
               clr_pin_o   = isr_pin_i;
            end
            ptr_load_o = clr_valid_o && cmd_i.rotate;
            ptr_val_o  = clr_pin_o;
         end else if (cmd_i.specific && cmd_i.rotate) begin
            ptr_load_o = 1'b1;
            ptr_val_o  = level_i;
         end
      end
   end
endmodule

// File: rtl/prio_irq_resolver.sv
module prio_irq_resolver
   import irq_res_pkg::*;
#(
   parameter int NUM_LINES = 8,
   parameter int VEC_W     = 8,
   parameter int RESET_PTR = NUM_LINES - 1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          init_done,
   input  logic                          aeoi_en,
   input  logic [VEC_W-$clog2(NUM_LINES)-1:0] vec_base,
   input  logic                          mask_we,
   input  logic [NUM_LINES-1:0]          mask_wdata,
   input  logic [NUM_LINES-1:0]          req_set,
   input  logic [NUM_LINES-1:0]          line_level,
   input  logic                          cmd_valid,
   input  logic                          cmd_eoi,
   input  logic                          cmd_specific,
   input  logic                          cmd_rotate,
   input  logic [$clog2(NUM_LINES)-1:0]  cmd_level,
   input  logic                          ack,
   output logic                          irq,
   output logic [VEC_W-1:0]              ack_vector,
   output logic [NUM_LINES-1:0]          irr_q,
   output logic [NUM_LINES-1:0]          isr_q,
   output logic [NUM_LINES-1:0]          imr_q
);
   localparam int PTR_W = $clog2(NUM_LINES);

   if (NUM_LINES != (1 << PTR_W)) begin : g_bad_lines
      $error("NUM_LINES must be a power of two");
   end
   if (VEC_W <= PTR_W) begin : g_bad_vec
      $error("VEC_W must exceed the line index width");
   end
   if (RESET_PTR < 0 || RESET_PTR >= NUM_LINES) begin : g_bad_ptr
      $error("RESET_PTR out of range");
   end

   logic [PTR_W-1:0] ptr_q;
   logic             rotate_q;

   logic             req_found, isr_found;
   logic [PTR_W-1:0] req_pos, isr_pos, req_pin, isr_pin;
   logic             eligible, ack_hit;

   irq_prio_scan #(.NUM_LINES(NUM_LINES), .PTR_W(PTR_W)) u_req_scan (
      .vec_i(irr_q & ~imr_q), .ptr_i(ptr_q),
      .found_o(req_found), .pos_o(req_pos), .pin_o(req_pin)
   );

   irq_prio_scan #(.NUM_LINES(NUM_LINES), .PTR_W(PTR_W)) u_isr_scan (
      .vec_i(isr_q), .ptr_i(ptr_q),
      .found_o(isr_found), .pos_o(isr_pos), .pin_o(isr_pin)
   );

   irq_cmd_t         cmd;
   logic             clr_valid, ptr_load;
   logic [PTR_W-1:0] clr_pin, ptr_val;

   assign cmd = '{eoi: cmd_eoi, specific: cmd_specific, rotate: cmd_rotate};

   irq_cmd_unit #(.PTR_W(PTR_W)) u_cmd (
      .cmd_valid_i(cmd_valid), .cmd_i(cmd), .level_i(cmd_level),
      .isr_found_i(isr_found), .isr_pin_i(isr_pin),
      .clr_valid_o(clr_valid), .clr_pin_o(clr_pin),
      .ptr_load_o(ptr_load), .ptr_val_o(ptr_val)
   );

   // A request wins only if it is strictly ahead of the first in-service line.
   assign eligible   = req_found && (!isr_found || (req_pos < isr_pos));
   assign ack_hit    = ack && eligible;
   assign ack_vector = {vec_base, (eligible ? req_pin : PTR_W'(NUM_LINES - 1))};

   logic [NUM_LINES-1:0] irr_clr, isr_set, isr_clr, req_gated;

   always_comb begin
      irr_clr = '0;
      isr_set = '0;
      isr_clr = '0;
      if (ack_hit && !line_level[req_pin]) irr_clr[req_pin] = 1'b1;
      if (ack_hit && !aeoi_en)             isr_set[req_pin] = 1'b1;
      if (clr_valid)                       isr_clr[clr_pin] = 1'b1;
   end

   assign req_gated = init_done ? req_set : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irr_q    <= '0;
         isr_q    <= '0;
         imr_q    <= '0;
         ptr_q    <= PTR_W'(RESET_PTR);
         rotate_q <= 1'b0;
         irq      <= 1'b0;
      end else begin
         irr_q <= (irr_q & ~irr_clr) | req_gated;
         isr_q <= (isr_q & ~isr_clr) | isr_set;
         irq   <= init_done && eligible;
         if (mask_we)   imr_q    <= mask_wdata;
         if (cmd_valid) rotate_q <= cmd_rotate;
         if (ptr_load)
            ptr_q <= ptr_val;
         else if (ack_hit && aeoi_en && rotate_q)
            ptr_q <= req_pin;
      end
   end

   // R8: normal-mode acknowledge marks the winning line in service
   a_r8_isr_set_on_ack : assert property (@(posedge clk) disable iff (!rst_n)
      (ack_hit && !aeoi_en && !cmd_valid) |=> isr_q[$past(req_pin)]);

   // R9: automatic EOI never touches the in-service register on acknowledge
   a_r9_aeoi_keeps_isr : assert property (@(posedge clk) disable iff (!rst_n)
      (ack && aeoi_en && !cmd_valid) |=> $stable(isr_q));

   // R6: a spurious acknowledge leaves pending and in-service state alone
   a_r6_spurious_quiet : assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !eligible && !cmd_valid && (req_set == '0)) |=> ($stable(isr_q) && $stable(irr_q)));

   // R5: no interrupt output unless initialised
   a_r5_irq_needs_init : assert property (@(posedge clk) disable iff (!rst_n)
      !init_done |=> !irq);

   // R7: a line still asserted keeps its pending bit across acknowledge
   a_r7_level_holds_irr : assert property (@(posedge clk) disable iff (!rst_n)
      (ack_hit && line_level[req_pin]) |=> irr_q[$past(req_pin)]);

   // R11: non-specific EOI with nothing in service is a no-op
   a_r11_empty_eoi_noop : assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_eoi && !cmd_specific && (isr_q == '0) && !ack) |=> (isr_q == '0));
endmodule

// File: tb/prio_irq_resolver_bench.sv
module prio_irq_resolver_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       init_done = 1'b0, aeoi_en = 1'b0;
   logic [4:0] vec_base = 5'h04;
   logic       mask_we = 1'b0;
   logic [7:0] mask_wdata = '0, req_set = '0, line_level = '0;
   logic       cmd_valid = 1'b0, cmd_eoi = 1'b0, cmd_specific = 1'b0, cmd_rotate = 1'b0;
   logic [2:0] cmd_level = '0;
   logic       ack = 1'b0;
   logic       irq;
   logic [7:0] ack_vector, irr_q, isr_q, imr_q;

   int checks = 0, errors = 0;

   always #10 clk = ~clk;

   prio_irq_resolver u_prio_irq_resolver (
      .clk, .rst_n, .init_done, .aeoi_en, .vec_base, .mask_we, .mask_wdata,
      .req_set, .line_level, .cmd_valid, .cmd_eoi, .cmd_specific, .cmd_rotate,
      .cmd_level, .ack, .irq, .ack_vector, .irr_q, .isr_q, .imr_q
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic pulse_req(input logic [7:0] r);
      req_set = r;
      @(negedge clk);
      req_set = '0;
   endtask

   task automatic write_mask(input logic [7:0] m);
      mask_we = 1'b1; mask_wdata = m;
      @(negedge clk);
      mask_we = 1'b0;
   endtask

   task automatic send_cmd(input logic e, input logic s, input logic r, input logic [2:0] lv);
      cmd_valid = 1'b1; cmd_eoi = e; cmd_specific = s; cmd_rotate = r; cmd_level = lv;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   // Drives an acknowledge, checks the vector before the acting edge.
   task automatic do_ack(input string tag, input logic [7:0] exp_vec);
      ack = 1'b1;
      #1 chk(tag, ack_vector, exp_vec);
      @(negedge clk);
      ack = 1'b0;
   endtask

   // {mask, request pulse, expected irq, expected winning line}; pointer at 7.
   localparam int NV = 6;
   localparam logic [19:0] TBL [NV] = '{
      {8'h00, 8'h81, 1'b1, 3'd0},
      {8'h01, 8'h81, 1'b1, 3'd7},
      {8'hFF, 8'h0F, 1'b0, 3'd7},
      {8'h00, 8'h50, 1'b1, 3'd4},
      {8'h0F, 8'h0C, 1'b0, 3'd7},
      {8'h00, 8'h00, 1'b0, 3'd7}
   };

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      do_reset();
      // R1: reset state
      chk("R1 irr", irr_q, 8'h00);
      chk("R1 isr", isr_q, 8'h00);
      chk("R1 imr", imr_q, 8'h00);
      chk("R1 irq", {7'd0, irq}, 8'h00);
      chk("R1 spurious vector", ack_vector, 8'h27);

      // R2: requests ignored before initialisation
      pulse_req(8'h10);
      chk("R2 ignored before init", irr_q, 8'h00);

      // Table walk: R3 scan order, R4 masking, R5 irq, R6 vector
      for (int k = 0; k < NV; k++) begin
         do_reset();
         init_done = 1'b1;
         write_mask(TBL[k][19:12]);
         chk("R13 mask readback", imr_q, TBL[k][19:12]);
         pulse_req(TBL[k][11:4]);
         chk("R2 pending set", irr_q, TBL[k][11:4]);
         chk("R5 irq not yet", {7'd0, irq}, 8'h00);
         chk("R3 R4 R6 table vector", ack_vector, {5'h04, TBL[k][2:0]});
         @(negedge clk);
         chk("R5 irq table", {7'd0, irq}, {7'd0, TBL[k][3]});
      end

      // Directed corner cases
      do_reset();
      init_done = 1'b1;
      line_level = 8'h08;
      pulse_req(8'h08);
      do_ack("R6 vector line3", 8'h23);
      chk("R8 isr set", isr_q, 8'h08);
      chk("R7 level keeps pending", irr_q, 8'h08);
      line_level = 8'h00;
      do_ack("R4 R6 in-service blocks itself", 8'h27);
      chk("R6 spurious keeps isr", isr_q, 8'h08);
      chk("R6 spurious keeps irr", irr_q, 8'h08);

      pulse_req(8'h20);
      chk("R4 lower request blocked", ack_vector, 8'h27);
      @(negedge clk);
      chk("R4 R5 irq low when blocked", {7'd0, irq}, 8'h00);
      pulse_req(8'h02);
      do_ack("R4 higher request wins", 8'h21);
      chk("R7 pending cleared", irr_q, 8'h28);
      chk("R8 two in service", isr_q, 8'h0A);

      send_cmd(1'b1, 1'b0, 1'b0, 3'd0);
      chk("R11 clears highest", isr_q, 8'h08);
      send_cmd(1'b1, 1'b0, 1'b0, 3'd0);
      chk("R11 clears next", isr_q, 8'h00);
      chk("R11 line3 wins again", ack_vector, 8'h23);
      send_cmd(1'b1, 1'b0, 1'b0, 3'd0);
      chk("R11 empty eoi no-op", isr_q, 8'h00);

      do_ack("R6 ack line3", 8'h23);
      chk("R7 line3 pending cleared", irr_q, 8'h20);
      send_cmd(1'b1, 1'b1, 1'b1, 3'd3);
      chk("R10 specific eoi", isr_q, 8'h00);
      pulse_req(8'h11);
      chk("R10 R3 rotated to line4", ack_vector, 8'h24);

      send_cmd(1'b0, 1'b1, 1'b1, 3'd4);
      chk("R12 set priority", ack_vector, 8'h25);
      chk("R12 isr untouched", isr_q, 8'h00);

      aeoi_en = 1'b1;
      do_ack("R9 ack line5", 8'h25);
      chk("R9 no isr set", isr_q, 8'h00);
      chk("R9 pending cleared", irr_q, 8'h11);
      chk("R9 rotated to line0", ack_vector, 8'h20);

      init_done = 1'b0;
      @(negedge clk);
      chk("R5 irq low without init", {7'd0, irq}, 8'h00);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule